// File: doc/BRIEF.md
# Split Instruction/Data Translation Cache

This block caches virtual-to-physical page translations for a processor core. It has two separate direct-mapped arrays. One serves instruction fetches only. The other serves every data access: reads, writes and read-modify-writes. Because the arrays are separate, a hot code page and a hot data page that share an index no longer evict each other. Each array keeps its own permission-bit layout. A lookup presents a linear address together with a user flag, a write flag and an execute flag. One cycle later the block reports whether the lookup hit, and on a hit it also returns the physical frame number.

Permissions are granted lazily. A fill, which is the result of a page walk, writes the translation into the array chosen by its access kind. It records only the rights the triggering access actually needed, within what the page allows. A later access that needs more right misses and causes a fresh walk. Maintenance comes in three forms: a full flush, a flush that spares global pages, and a single-page invalidate that is applied to both arrays. Each array also carries a sticky flag that records that a large-page translation has been cached in it.

Top module: `split_tlb`

## Requirements
- R1: Execute lookups and fills use only the instruction array. All other lookups and fills use only the data array. A translation cached in one array never makes a lookup of the other kind hit.
- R2: The block answers a lookup in the cycle after it is presented. `rsp_valid` is high for exactly that cycle. `rsp_pfn` carries the stored frame on a hit and zero on a miss.
- R3: A hit needs two things: the stored linear page number must equal `lk_addr[VA_W-1:12]`, and the permission bit selected by the access must be set. In the data array the bits are supervisor read (bit 0), user read (bit 1), supervisor write (bit 2) and user write (bit 3), and the tested bit index is `{write,user}`. In the instruction array the bits are supervisor execute (bit 0) and user execute (bit 1), and the tested bit index is `user`.
- R4: The array index is the low log2(ENTRIES) bits of the linear page number. A fill overwrites the entry at that index unconditionally.
- R5: With paging enabled, a data fill sets supervisor read. It adds supervisor write only when the access was a write. It sets user read, and user write if the access was a write, only when the page is user-accessible and the access came from user mode.
- R6: With paging enabled, an execute fill sets supervisor execute. It sets user execute only when the page is user-accessible and the access came from user mode.
- R7: With paging disabled, an execute fill sets both execute bits. A data fill sets supervisor read, user read and user write, and sets supervisor write only for a write access.
- R8: On a user-accessible page with paging enabled, `smep_en` clears supervisor execute on an execute fill, and `smap_en` clears supervisor read and write on a data fill. On a supervisor-only page, neither enable has any effect.
- R9: `flush_all` invalidates every entry in both arrays and clears both large-page flags.
- R10: `flush_local` invalidates every entry in both arrays except those filled with `fill_global` set, and leaves the large-page flags unchanged.
- R11: `inval_valid` applies to both arrays. It clears the entry at the index of `inval_addr` only if that entry's page number matches, so a different page at the same index survives. If the array's large-page flag is set, it also clears every large-page entry in that array.
- R12: Each array's large-page flag (`itlb_large`, `dtlb_large`) becomes 1 after a fill with `fill_large` set into that array. It stays 1 until `flush_all`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | VA_W | Lookup linear address |
| lk_user | input | 1 | Lookup from user mode |
| lk_write | input | 1 | Lookup is a write |
| lk_exec | input | 1 | Lookup is an instruction fetch |
| rsp_valid | output | 1 | Response strobe, one cycle after lookup |
| rsp_hit | output | 1 | Tag matched and permission granted |
| rsp_pfn | output | PA_W-12 | Physical frame number on hit, else zero |
| fill_valid | input | 1 | Install a translation |
| fill_addr | input | VA_W | Linear address of the filled page |
| fill_pfn | input | PA_W-12 | Physical frame to store |
| fill_user | input | 1 | Triggering access was user mode |
| fill_write | input | 1 | Triggering access was a write |
| fill_exec | input | 1 | Triggering access was a fetch |
| fill_page_user | input | 1 | Page is user-accessible |
| fill_global | input | 1 | Page is global |
| fill_large | input | 1 | Translation came from a page larger than 4 KiB |
| paging_en | input | 1 | Paging enabled |
| smep_en | input | 1 | Supervisor execution prevention enabled |
| smap_en | input | 1 | Supervisor access prevention enabled |
| flush_all | input | 1 | Invalidate everything |
| flush_local | input | 1 | Invalidate all non-global entries |
| inval_valid | input | 1 | Single-page invalidate |
| inval_addr | input | VA_W | Address of page to invalidate |
| itlb_large | output | 1 | Sticky large-page flag, instruction array |
| dtlb_large | output | 1 | Sticky large-page flag, data array |

## Verification
Lookups run against fills made under many combinations of mode, write, page-user, paging and prevention enables. This shows that each permission bit is granted only for the access kind that created it. Probing the same address with fetch and data lookups separates the two arrays. Two pages that share an index separate overwrite from coexistence, and they also separate a tag-checked invalidate from a blind clear by index. Global, non-global and large-page entries are mixed before each flush kind and before an unrelated invalidate, which shows which entries each operation may remove.

// File: rtl/split_tlb_pkg.sv
// Shared constants for the split translation cache: permission bit
// positions in each array and the page geometry.
package split_tlb_pkg;
    localparam int PAGE_SHIFT = 12;

    // Data array permission bits, indexed by {write,user}
    localparam int D_PERM_W  = 4;
    localparam int D_SUP_RD  = 0;
    localparam int D_USR_RD  = 1;
    localparam int D_SUP_WR  = 2;
    localparam int D_USR_WR  = 3;

    // Instruction array permission bits, indexed by user
    localparam int I_PERM_W  = 2;
    localparam int I_SUP_EX  = 0;
    localparam int I_USR_EX  = 1;
endpackage

// File: rtl/tlb_perm.sv
// Computes the permission bits written on a fill. Rights are granted lazily:
// only the kind of access that caused the fill is recorded, limited by the
// page's user bit, the paging enable and the prevention enables.
// Assumes: purely combinational, evaluated every cycle.
module tlb_perm
    import split_tlb_pkg::*;
(
    input  logic                fill_user,
    input  logic                fill_write,
    input  logic                page_user,
    input  logic                paging_en,
    input  logic                smep_en,
    input  logic                smap_en,
    output logic [I_PERM_W-1:0] i_perm,
    output logic [D_PERM_W-1:0] d_perm
);
    logic user_ok;
    logic guard_page;

    assign user_ok    = !paging_en || (page_user && fill_user);
    assign guard_page = paging_en && page_user;

    // Instruction fill: execute rights only
    always_comb begin
        i_perm           = '0;
        i_perm[I_SUP_EX] = !(guard_page && smep_en);
        i_perm[I_USR_EX] = user_ok;
    end

    // Data fill: read always, write only for write accesses
    always_comb begin
        d_perm           = '0;
        d_perm[D_SUP_RD] = !(guard_page && smap_en);
        d_perm[D_SUP_WR] = fill_write && !(guard_page && smap_en);
        d_perm[D_USR_RD] = user_ok;
        d_perm[D_USR_WR] = user_ok && (fill_write || !paging_en);
    end

    // Prevention enables never leave a supervisor right on a user page
    always_comb begin
        // R8
        smep_clear_chk: assert (!(guard_page && smep_en) || !i_perm[I_SUP_EX]);
        // R8
        smap_clear_chk: assert (!(guard_page && smap_en) || (d_perm[D_SUP_RD] == 1'b0 && d_perm[D_SUP_WR] == 1'b0));
        // R5
        no_user_on_sup_chk: assert (!(paging_en && !page_user) || (d_perm[D_USR_RD] == 1'b0 && i_perm[I_USR_EX] == 1'b0));
    end
endmodule

// File: rtl/tlb_array.sv
// One direct-mapped translation array. Lookups are registered: the result
// appears one cycle after the request. Storage words carry no reset. Only the
// valid, global and large vectors are reset, so a flush costs one cycle.
// Assumes: at most one of flush_all, flush_local, inv_en, wr_en is acted on
// per cycle, in that priority.
module tlb_array #(
    parameter int ENTRIES = 2048,
    parameter int VPN_W   = 36,
    parameter int PFN_W   = 28,
    parameter int PERM_W  = 4,
    parameter int SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_en,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [SEL_W-1:0]  lk_sel,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              wr_global,
    input  logic              wr_large,
    input  logic              flush_all,
    input  logic              flush_local,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    output logic              large_flag
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0]  tag_mem  [ENTRIES];
    logic [PFN_W-1:0]  pfn_mem  [ENTRIES];
    logic [PERM_W-1:0] perm_mem [ENTRIES];
    logic [ENTRIES-1:0] valid_q, glob_q, large_q, inv_keep;

    logic [IDX_W-1:0] lidx, widx, iidx;
    logic             lk_match, inv_match, wr_go;

    assign lidx  = lk_vpn[IDX_W-1:0];
    assign widx  = wr_vpn[IDX_W-1:0];
    assign iidx  = inv_vpn[IDX_W-1:0];
    assign wr_go = wr_en && !flush_all && !flush_local && !inv_en;

    // Lookup compare: tag equality and the selected permission bit
    assign lk_match  = valid_q[lidx] && (tag_mem[lidx] == lk_vpn) && perm_mem[lidx][lk_sel];
    // Invalidate compare: indexed entry holds exactly this page
    assign inv_match = valid_q[iidx] && (tag_mem[iidx] == inv_vpn);

    // Entries surviving an invalidate
    always_comb begin
        inv_keep = large_flag ? ~large_q : '1;
        if (inv_match) inv_keep[iidx] = 1'b0;
    end

    // Valid, global, large vectors and the sticky large-page flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= '0;
            glob_q     <= '0;
            large_q    <= '0;
            large_flag <= 1'b0;
        end else if (flush_all) begin
            valid_q    <= '0;
            large_flag <= 1'b0;
        end else if (flush_local) begin
            valid_q    <= valid_q & glob_q;
        end else if (inv_en) begin
            valid_q    <= valid_q & inv_keep;
        end else if (wr_en) begin
            valid_q[widx] <= 1'b1;
            glob_q[widx]  <= wr_global;
            large_q[widx] <= wr_large;
            if (wr_large) large_flag <= 1'b1;
        end
    end

    // Translation storage, overwritten on every accepted fill
    always_ff @(posedge clk) begin
        if (wr_go) begin
            tag_mem[widx]  <= wr_vpn;
            pfn_mem[widx]  <= wr_pfn;
            perm_mem[widx] <= wr_perm;
        end
    end

    // Registered lookup result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit <= 1'b0;
            rsp_pfn <= '0;
        end else begin
            rsp_hit <= lk_en && lk_match;
            rsp_pfn <= (lk_en && lk_match) ? pfn_mem[lidx] : '0;
        end
    end

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0 && !large_flag));
    // R10
    global_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_local && !flush_all) |=> ((valid_q & ~glob_q) == '0));
    // R12
    large_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_large) |=> large_flag);
    // R2
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $past(lk_en));
endmodule

// File: rtl/split_tlb.sv
// Split translation cache top. It routes fetch traffic to the instruction
// array and every other access to the data array, builds fill permissions and
// fans maintenance operations out to both arrays.
// Assumes: the page walker supplies fill attributes; faults are handled outside.
module split_tlb
    import split_tlb_pkg::*;
#(
    parameter int VA_W        = 48,
    parameter int PA_W        = 40,
    parameter int ITLB_ENTRIES = 2048,
    parameter int DTLB_ENTRIES = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [VA_W-1:0]          lk_addr,
    input  logic                     lk_user,
    input  logic                     lk_write,
    input  logic                     lk_exec,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [PA_W-PAGE_SHIFT-1:0] rsp_pfn,
    input  logic                     fill_valid,
    input  logic [VA_W-1:0]          fill_addr,
    input  logic [PA_W-PAGE_SHIFT-1:0] fill_pfn,
    input  logic                     fill_user,
    input  logic                     fill_write,
    input  logic                     fill_exec,
    input  logic                     fill_page_user,
    input  logic                     fill_global,
    input  logic                     fill_large,
    input  logic                     paging_en,
    input  logic                     smep_en,
    input  logic                     smap_en,
    input  logic                     flush_all,
    input  logic                     flush_local,
    input  logic                     inval_valid,
    input  logic [VA_W-1:0]          inval_addr,
    output logic                     itlb_large,
    output logic                     dtlb_large
);
    localparam int VPN_W = VA_W - PAGE_SHIFT;
    localparam int PFN_W = PA_W - PAGE_SHIFT;

    logic [VPN_W-1:0]    lk_vpn, fill_vpn, inv_vpn;
    logic [I_PERM_W-1:0] i_perm;
    logic [D_PERM_W-1:0] d_perm;
    logic                i_hit, d_hit, rsp_from_i;
    logic [PFN_W-1:0]    i_pfn, d_pfn;

    assign lk_vpn   = lk_addr[VA_W-1:PAGE_SHIFT];
    assign fill_vpn = fill_addr[VA_W-1:PAGE_SHIFT];
    assign inv_vpn  = inval_addr[VA_W-1:PAGE_SHIFT];

    tlb_perm u_perm (
        .fill_user (fill_user),
        .fill_write(fill_write),
        .page_user (fill_page_user),
        .paging_en (paging_en),
        .smep_en   (smep_en),
        .smap_en   (smap_en),
        .i_perm    (i_perm),
        .d_perm    (d_perm)
    );

    tlb_array #(
        .ENTRIES(ITLB_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
        .PERM_W(I_PERM_W), .SEL_W(1)
    ) u_itlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_en      (lk_valid && lk_exec),
        .lk_vpn     (lk_vpn),
        .lk_sel     (lk_user),
        .rsp_hit    (i_hit),
        .rsp_pfn    (i_pfn),
        .wr_en      (fill_valid && fill_exec),
        .wr_vpn     (fill_vpn),
        .wr_pfn     (fill_pfn),
        .wr_perm    (i_perm),
        .wr_global  (fill_global),
        .wr_large   (fill_large),
        .flush_all  (flush_all),
        .flush_local(flush_local),
        .inv_en     (inval_valid),
        .inv_vpn    (inv_vpn),
        .large_flag (itlb_large)
    );

    tlb_array #(
        .ENTRIES(DTLB_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
        .PERM_W(D_PERM_W), .SEL_W(2)
    ) u_dtlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_en      (lk_valid && !lk_exec),
        .lk_vpn     (lk_vpn),
        .lk_sel     ({lk_write, lk_user}),
        .rsp_hit    (d_hit),
        .rsp_pfn    (d_pfn),
        .wr_en      (fill_valid && !fill_exec),
        .wr_vpn     (fill_vpn),
        .wr_pfn     (fill_pfn),
        .wr_perm    (d_perm),
        .wr_global  (fill_global),
        .wr_large   (fill_large),
        .flush_all  (flush_all),
        .flush_local(flush_local),
        .inv_en     (inval_valid),
        .inv_vpn    (inv_vpn),
        .large_flag (dtlb_large)
    );

    // Response strobe and the array that answers it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_from_i <= 1'b0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_from_i <= lk_exec;
        end
    end

    assign rsp_hit = rsp_from_i ? i_hit : d_hit;
    assign rsp_pfn = rsp_from_i ? i_pfn : d_pfn;

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R1
    one_array_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_hit && d_hit));
    // R2
    miss_zero_pfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0));
endmodule

// File: tb/tb_split_tlb.sv
// Scoreboard bench: lookup tasks queue expected results, a monitor compares.
module tb_split_tlb;
    localparam int VA_W  = 48;
    localparam int PA_W  = 40;
    localparam int PFN_W = PA_W - 12;

    logic clk = 0;
    logic rst_n = 0;
    logic lk_valid = 0, lk_user = 0, lk_write = 0, lk_exec = 0;
    logic [VA_W-1:0] lk_addr = '0;
    logic rsp_valid, rsp_hit;
    logic [PFN_W-1:0] rsp_pfn;
    logic fill_valid = 0, fill_user = 0, fill_write = 0, fill_exec = 0;
    logic fill_page_user = 0, fill_global = 0, fill_large = 0;
    logic [VA_W-1:0] fill_addr = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic paging_en = 1, smep_en = 0, smap_en = 0;
    logic flush_all = 0, flush_local = 0, inval_valid = 0;
    logic [VA_W-1:0] inval_addr = '0;
    logic itlb_large, dtlb_large;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic             hit;
        logic [PFN_W-1:0] pfn;
        string            req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    split_tlb dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_user(lk_user),
        .lk_write(lk_write), .lk_exec(lk_exec),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_pfn(fill_pfn),
        .fill_user(fill_user), .fill_write(fill_write), .fill_exec(fill_exec),
        .fill_page_user(fill_page_user), .fill_global(fill_global),
        .fill_large(fill_large), .paging_en(paging_en), .smep_en(smep_en),
        .smap_en(smap_en), .flush_all(flush_all), .flush_local(flush_local),
        .inval_valid(inval_valid), .inval_addr(inval_addr),
        .itlb_large(itlb_large), .dtlb_large(dtlb_large)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare each response with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2 unexpected response", 64'(rsp_hit), 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_hit == e.hit, e.req, 64'(rsp_hit), 64'(e.hit));
                chk(rsp_pfn == e.pfn, {e.req, " pfn"}, 64'(rsp_pfn), 64'(e.pfn));
            end
        end
    end

    task automatic step_end();
        @(posedge clk); #1;
        lk_valid = 0; fill_valid = 0; flush_all = 0; flush_local = 0; inval_valid = 0;
    endtask

    task automatic lookup(input logic [VA_W-1:0] a, input logic u, input logic w, input logic x,
                          input logic eh, input logic [PFN_W-1:0] ep, input string req);
        exp_t e;
        lk_valid = 1; lk_addr = a; lk_user = u; lk_write = w; lk_exec = x;
        e.hit = eh; e.pfn = eh ? ep : '0; e.req = req;
        sb.push_back(e);
        step_end();
    endtask

    task automatic fill(input logic [VA_W-1:0] a, input logic [PFN_W-1:0] p, input logic u,
                        input logic w, input logic x, input logic pu, input logic g,
                        input logic lg, input logic pg, input logic sme, input logic sma);
        fill_valid = 1; fill_addr = a; fill_pfn = p; fill_user = u; fill_write = w;
        fill_exec = x; fill_page_user = pu; fill_global = g; fill_large = lg;
        paging_en = pg; smep_en = sme; smap_en = sma;
        step_end();
    endtask

    task automatic inval(input logic [VA_W-1:0] a);
        inval_valid = 1; inval_addr = a;
        step_end();
    endtask

    localparam logic [VA_W-1:0] A  = 48'h0000_1234_5000;
    localparam logic [VA_W-1:0] A2 = 48'h0000_12B4_5000; // same index as A
    localparam logic [VA_W-1:0] B  = 48'h0000_0000_7000;
    localparam logic [VA_W-1:0] C  = 48'h0000_0000_8000;
    localparam logic [VA_W-1:0] D  = 48'h0000_0000_9000;
    localparam logic [VA_W-1:0] E  = 48'h0000_0000_A000;
    localparam logic [VA_W-1:0] F  = 48'h0000_0000_B000;
    localparam logic [VA_W-1:0] G  = 48'h0000_4000_0000;
    localparam logic [VA_W-1:0] H  = 48'h0000_0000_D000;
    localparam logic [VA_W-1:0] K  = 48'h0000_0000_C000;

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R9 reset state: no response, flags clear
        chk(rsp_valid == 0, "R2 reset rsp_valid", 64'(rsp_valid), 0);
        chk(itlb_large == 0 && dtlb_large == 0, "R12 reset flags", 64'({itlb_large, dtlb_large}), 0);
        @(posedge clk); #1;

        // R5 R3: supervisor read fill grants supervisor read only
        fill(A, 28'h111, 0, 0, 0, 1, 0, 0, 1, 0, 0);
        lookup(A, 0, 0, 0, 1, 28'h111, "R3 sup read hit");
        lookup(A, 0, 1, 0, 0, 0, "R5 sup write not granted");
        lookup(A, 1, 0, 0, 0, 0, "R5 user read not granted");
        // R1: instruction array empty at A
        lookup(A, 0, 0, 1, 0, 0, "R1 fetch misses data entry");
        // R6: user fetch fill
        fill(A, 28'h222, 1, 0, 1, 1, 0, 0, 1, 0, 0);
        lookup(A, 1, 0, 1, 1, 28'h222, "R6 user fetch hit");
        lookup(A, 0, 0, 1, 1, 28'h222, "R6 sup fetch hit");
        lookup(A, 0, 0, 0, 1, 28'h111, "R1 data entry kept");
        // R5: user write on user page grants all four
        fill(B, 28'h333, 1, 1, 0, 1, 0, 0, 1, 0, 0);
        lookup(B, 1, 1, 0, 1, 28'h333, "R5 user write hit");
        lookup(B, 1, 0, 0, 1, 28'h333, "R5 user read hit");
        lookup(B, 0, 1, 0, 1, 28'h333, "R5 sup write hit");
        lookup(B, 1, 0, 1, 0, 0, "R1 fetch of data page");
        // R5: supervisor write on user page, no user rights
        fill(C, 28'h444, 0, 1, 0, 1, 0, 0, 1, 0, 0);
        lookup(C, 0, 1, 0, 1, 28'h444, "R5 sup write hit");
        lookup(C, 1, 0, 0, 0, 0, "R5 user read denied");
        // R6: supervisor fetch on user page, no user execute
        fill(C, 28'h445, 0, 0, 1, 1, 0, 0, 1, 0, 0);
        lookup(C, 1, 0, 1, 0, 0, "R6 user fetch denied");
        // R7: paging off
        fill(D, 28'h555, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        lookup(D, 1, 1, 0, 1, 28'h555, "R7 user write granted");
        lookup(D, 0, 1, 0, 0, 0, "R7 sup write not granted");
        fill(D, 28'h556, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        lookup(D, 1, 0, 1, 1, 28'h556, "R7 user fetch granted");
        // R8: prevention enables on user pages
        fill(E, 28'h666, 1, 1, 0, 1, 0, 0, 1, 0, 1);
        lookup(E, 0, 0, 0, 0, 0, "R8 smap clears sup read");
        lookup(E, 1, 1, 0, 1, 28'h666, "R8 user write kept");
        fill(E, 28'h667, 1, 0, 1, 1, 0, 0, 1, 1, 0);
        lookup(E, 0, 0, 1, 0, 0, "R8 smep clears sup exec");
        lookup(E, 1, 0, 1, 1, 28'h667, "R8 user exec kept");
        fill(F, 28'h668, 0, 0, 0, 0, 0, 0, 1, 1, 1);
        lookup(F, 0, 0, 0, 1, 28'h668, "R8 sup page unaffected");
        // R4: collision overwrite
        fill(A2, 28'h777, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        lookup(A2, 0, 0, 0, 1, 28'h777, "R4 new entry hit");
        lookup(A, 0, 0, 0, 0, 0, "R4 old entry evicted");
        // R11: tag-checked invalidate across both arrays
        inval(A);
        lookup(A2, 0, 0, 0, 1, 28'h777, "R11 other page survives");
        lookup(A, 0, 0, 1, 0, 0, "R11 fetch entry invalidated");
        inval(A2);
        lookup(A2, 0, 0, 0, 0, 0, "R11 matching page invalidated");
        // R12: large-page flag and large invalidation
        fill(G, 28'h888, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        @(negedge clk);
        chk(dtlb_large == 1, "R12 data flag set", 64'(dtlb_large), 1);
        chk(itlb_large == 0, "R12 inst flag untouched", 64'(itlb_large), 0);
        @(posedge clk); #1;
        fill(H, 28'h999, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        lookup(G, 0, 0, 0, 1, 28'h888, "R12 large entry hit");
        inval(F);
        lookup(G, 0, 0, 0, 0, 0, "R11 large entry dropped");
        lookup(H, 0, 0, 0, 1, 28'h999, "R11 small entry kept");
        // R10: non-global flush
        fill(K, 28'hAAA, 0, 0, 0, 0, 1, 0, 1, 0, 0);
        flush_local = 1; step_end();
        lookup(K, 0, 0, 0, 1, 28'hAAA, "R10 global kept");
        lookup(B, 1, 1, 0, 0, 0, "R10 non-global removed");
        lookup(D, 1, 0, 1, 0, 0, "R10 fetch entry removed");
        @(negedge clk);
        chk(dtlb_large == 1, "R10 flag unchanged", 64'(dtlb_large), 1);
        @(posedge clk); #1;
        // R9: full flush
        flush_all = 1; step_end();
        lookup(K, 0, 0, 0, 0, 0, "R9 global removed");
        @(negedge clk);
        chk(dtlb_large == 0, "R9 flag cleared", 64'(dtlb_large), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sb.size() == 0, "R2 all responses seen", 64'(sb.size()), 0);
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule